// File: doc/BRIEF.md
# Per-Component Energy Accumulator

This block keeps a running energy tally for the parts of a solid-state storage device: the controller, the DRAM, every flash die and the host bus. On each tick every component reports what it is doing. The block then adds that state's energy per tick to the component's own accumulator. Each energy-per-tick constant is precomputed outside the block as state current times supply voltage times tick length, in fixed point. The block receives these as programmable inputs, so one tick costs only an addition per accumulator.

Flash dies have separate costs for read, write and erase, plus an idle cost. A powered-off die adds nothing. The host bus adds energy only while a transfer is in progress. A separate accumulator counts idle-die energy only in ticks where at least one die is busy, which shows how much energy idle dies spend waiting on busy ones. A grand-total accumulator sums every component. All accumulators saturate instead of wrapping. A synchronous clear zeroes them all.

Top module: `nrg_meter`

## Requirements
- R1: Reset, or a high `clr` at a clock edge, sets every accumulator output to zero. `clr` takes priority over a tick in the same cycle.
- R2: A clock edge with `tick_en` low and `clr` low leaves every accumulator unchanged, whatever the state inputs are.
- R3: On a tick, `acc_ctl` grows by `e_ctl_act` when any of `ctl_host_cmd`, `ctl_gc` or `ctl_buf_mgmt` is high, and by `e_ctl_idle` otherwise.
- R4: On a tick, `acc_dram` grows by `e_dram_act` when `dram_busy` is high, and by `e_dram_idle` otherwise.
- R5: Each die has a 3-bit code at bits [3d+2:3d] of `die_state`: 0 powered off, 1 idle, 2 read, 3 write, 4 erase, and 5 to 7 treated as powered off. On a tick, die d's accumulator, at bits [AW*d+AW-1:AW*d] of `acc_die`, grows by 0, `e_fl_idle`, `e_fl_read`, `e_fl_write`, `e_fl_erase` and 0 respectively.
- R6: The bus code `bus_state` is 0 off, 1 idle, 2 transferring, and 3 treated as off. On a tick, `acc_bus` grows by `e_bus_xfer` only for code 2 and by nothing otherwise.
- R7: On a tick, `acc_fl_idle` grows by `e_fl_idle` times the number of idle dies (code 1), but only if at least one die has code 2, 3 or 4. Otherwise it does not change.
- R8: On a tick, `acc_total` grows by the sum of the increments added that tick to `acc_ctl`, `acc_dram`, all die accumulators and `acc_bus`.
- R9: Every accumulator saturates at 2^AW-1: an addition that would exceed this leaves the accumulator at 2^AW-1, and it never wraps.
- R10: An accumulator output shows a tick's contribution after the clock edge at which `tick_en` was sampled high, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all accumulators |
| tick_en | input | 1 | Accumulation tick |
| ctl_host_cmd | input | 1 | Controller is serving a host command |
| ctl_gc | input | 1 | Controller is collecting garbage |
| ctl_buf_mgmt | input | 1 | Controller is managing buffers |
| dram_busy | input | 1 | DRAM read or write in progress |
| die_state | input | 3*ND | Per-die state codes |
| bus_state | input | 2 | Host bus state code |
| e_ctl_act | input | EW | Controller active energy per tick |
| e_ctl_idle | input | EW | Controller idle energy per tick |
| e_dram_act | input | EW | DRAM active energy per tick |
| e_dram_idle | input | EW | DRAM idle energy per tick |
| e_fl_read | input | EW | Die read energy per tick |
| e_fl_write | input | EW | Die write energy per tick |
| e_fl_erase | input | EW | Die erase energy per tick |
| e_fl_idle | input | EW | Die idle energy per tick |
| e_bus_xfer | input | EW | Bus transfer energy per tick |
| acc_ctl | output | AW | Controller energy |
| acc_dram | output | AW | DRAM energy |
| acc_die | output | AW*ND | Per-die energy, die 0 in the low bits |
| acc_bus | output | AW | Host bus energy |
| acc_fl_idle | output | AW | Idle-die energy while another die is busy |
| acc_total | output | AW | Sum of all component energy |

## Verification
A wrong state decode or a wrong cost selection shows up at the affected accumulator one cycle after the offending tick, because each tick's addition is visible on the next edge. Sweeping every combination of die codes against changing controller, DRAM and bus states exposes any single code that adds the wrong constant, and the error stays visible from that point on because it is accumulated. A broken overlap condition or total sum shows up as a mismatch of `acc_fl_idle` or `acc_total` in the first tick whose die pattern exercises it. Wrapping instead of saturating shows up as a drop in value in the tick that crosses the limit.

// File: rtl/nrg_pkg.sv
package nrg_pkg;

  typedef enum logic [2:0] {
    DIE_OFF   = 3'd0,
    DIE_IDLE  = 3'd1,
    DIE_READ  = 3'd2,
    DIE_WRITE = 3'd3,
    DIE_ERASE = 3'd4
  } die_st_e;

  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_IDLE = 2'd1,
    BUS_XFER = 2'd2
  } bus_st_e;

  localparam int DIE_CODE_W = 3;
  localparam int BUS_CODE_W = 2;

endpackage

// File: rtl/nrg_sat_acc.sv
module nrg_sat_acc #(
  parameter int AW = 48,
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [AW-1:0] acc
);
  localparam int SW = ((AW > IW) ? AW : IW) + 1;
  localparam logic [SW-1:0] LIMIT = SW'({AW{1'b1}});

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(acc) + SW'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (en) begin
      if (sum > LIMIT) acc <= {AW{1'b1}};
      else             acc <= sum[AW-1:0];
    end
  end
endmodule

// File: rtl/nrg_die_cost.sv
module nrg_die_cost
  import nrg_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [DIE_CODE_W-1:0] code,
  input  logic [EW-1:0]         e_read,
  input  logic [EW-1:0]         e_write,
  input  logic [EW-1:0]         e_erase,
  input  logic [EW-1:0]         e_idle,
  output logic [EW-1:0]         cost,
  output logic                  busy,
  output logic                  idle
);
  die_st_e st;

  always_comb begin
    st   = die_st_e'(code);
    cost = '0;
    busy = 1'b0;
    idle = 1'b0;
    case (st)
      DIE_IDLE:  begin cost = e_idle;  idle = 1'b1; end
      DIE_READ:  begin cost = e_read;  busy = 1'b1; end
      DIE_WRITE: begin cost = e_write; busy = 1'b1; end
      DIE_ERASE: begin cost = e_erase; busy = 1'b1; end
      default:   begin cost = '0; end
    endcase
  end
endmodule

// File: rtl/nrg_overlap.sv
module nrg_overlap #(
  parameter int ND = 4,
  parameter int EW = 16,
  parameter int CW = $clog2(ND + 1),
  parameter int IW = EW + CW
) (
  input  logic [ND-1:0] idle_v,
  input  logic [ND-1:0] busy_v,
  input  logic [EW-1:0] e_idle,
  output logic [IW-1:0] inc
);
  logic [CW-1:0] n_idle;

  always_comb begin
    n_idle = '0;
    for (int d = 0; d < ND; d++) begin
      n_idle = n_idle + CW'(idle_v[d]);
    end
    if (|busy_v) inc = IW'(n_idle) * IW'(e_idle);
    else         inc = '0;
  end
endmodule

// File: rtl/nrg_meter.sv
module nrg_meter
  import nrg_pkg::*;
#(
  parameter int ND = 4,
  parameter int EW = 16,
  parameter int AW = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               tick_en,
  input  logic               ctl_host_cmd,
  input  logic               ctl_gc,
  input  logic               ctl_buf_mgmt,
  input  logic               dram_busy,
  input  logic [3*ND-1:0]    die_state,
  input  logic [1:0]         bus_state,
  input  logic [EW-1:0]      e_ctl_act,
  input  logic [EW-1:0]      e_ctl_idle,
  input  logic [EW-1:0]      e_dram_act,
  input  logic [EW-1:0]      e_dram_idle,
  input  logic [EW-1:0]      e_fl_read,
  input  logic [EW-1:0]      e_fl_write,
  input  logic [EW-1:0]      e_fl_erase,
  input  logic [EW-1:0]      e_fl_idle,
  input  logic [EW-1:0]      e_bus_xfer,
  output logic [AW-1:0]      acc_ctl,
  output logic [AW-1:0]      acc_dram,
  output logic [AW*ND-1:0]   acc_die,
  output logic [AW-1:0]      acc_bus,
  output logic [AW-1:0]      acc_fl_idle,
  output logic [AW-1:0]      acc_total
);
  localparam int CW = $clog2(ND + 1);
  localparam int OW = EW + CW;
  localparam int TW = EW + $clog2(ND + 4) + 1;

  logic [EW-1:0] ctl_cost, dram_cost, bus_cost;
  logic [EW-1:0] die_cost [ND];
  logic [ND-1:0] die_busy, die_idle;
  logic [OW-1:0] ovl_inc;
  logic [TW-1:0] tot_inc;
  bus_st_e       bus_st;

  // Controller: active whenever any activity source is asserted (R3)
  always_comb begin
    ctl_cost  = (ctl_host_cmd || ctl_gc || ctl_buf_mgmt) ? e_ctl_act : e_ctl_idle;
    dram_cost = dram_busy ? e_dram_act : e_dram_idle;
    bus_st    = bus_st_e'(bus_state);
    bus_cost  = (bus_st == BUS_XFER) ? e_bus_xfer : '0;
  end

  nrg_sat_acc #(.AW(AW), .IW(EW)) u_acc_ctl (
    .clk(clk), .rst(rst), .clr(clr), .en(tick_en), .inc(ctl_cost), .acc(acc_ctl)
  );

  nrg_sat_acc #(.AW(AW), .IW(EW)) u_acc_dram (
    .clk(clk), .rst(rst), .clr(clr), .en(tick_en), .inc(dram_cost), .acc(acc_dram)
  );

  nrg_sat_acc #(.AW(AW), .IW(EW)) u_acc_bus (
    .clk(clk), .rst(rst), .clr(clr), .en(tick_en), .inc(bus_cost), .acc(acc_bus)
  );

  // One cost decoder and accumulator per flash die (R5)
  for (genvar d = 0; d < ND; d++) begin : g_die
    nrg_die_cost #(.EW(EW)) u_cost (
      .code    (die_state[3*d +: 3]),
      .e_read  (e_fl_read),
      .e_write (e_fl_write),
      .e_erase (e_fl_erase),
      .e_idle  (e_fl_idle),
      .cost    (die_cost[d]),
      .busy    (die_busy[d]),
      .idle    (die_idle[d])
    );

    nrg_sat_acc #(.AW(AW), .IW(EW)) u_acc (
      .clk(clk), .rst(rst), .clr(clr), .en(tick_en),
      .inc(die_cost[d]), .acc(acc_die[AW*d +: AW])
    );
  end

  // Idle dies waiting on a busy die (R7)
  nrg_overlap #(.ND(ND), .EW(EW), .CW(CW), .IW(OW)) u_ovl (
    .idle_v (die_idle),
    .busy_v (die_busy),
    .e_idle (e_fl_idle),
    .inc    (ovl_inc)
  );

  nrg_sat_acc #(.AW(AW), .IW(OW)) u_acc_ovl (
    .clk(clk), .rst(rst), .clr(clr), .en(tick_en), .inc(ovl_inc), .acc(acc_fl_idle)
  );

  // Grand total from the same per-tick increments (R8)
  always_comb begin
    tot_inc = TW'(ctl_cost) + TW'(dram_cost) + TW'(bus_cost);
    for (int d = 0; d < ND; d++) begin
      tot_inc = tot_inc + TW'(die_cost[d]);
    end
  end

  nrg_sat_acc #(.AW(AW), .IW(TW)) u_acc_tot (
    .clk(clk), .rst(rst), .clr(clr), .en(tick_en), .inc(tot_inc), .acc(acc_total)
  );
endmodule

// File: rtl/nrg_meter_chk.sv
module nrg_meter_chk #(
  parameter int ND = 4,
  parameter int EW = 16,
  parameter int AW = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             tick_en,
  input logic             ctl_host_cmd,
  input logic             ctl_gc,
  input logic             ctl_buf_mgmt,
  input logic [3*ND-1:0]  die_state,
  input logic [1:0]       bus_state,
  input logic [EW-1:0]    e_ctl_act,
  input logic [EW-1:0]    e_ctl_idle,
  input logic [AW-1:0]    acc_ctl,
  input logic [AW-1:0]    acc_dram,
  input logic [AW-1:0]    acc_bus,
  input logic [AW-1:0]    acc_fl_idle,
  input logic [AW-1:0]    acc_total
);
  logic          any_busy;
  logic [AW:0]   ctl_expect;
  logic [EW-1:0] ctl_pick;

  always_comb begin
    any_busy = 1'b0;
    for (int d = 0; d < ND; d++) begin
      if (die_state[3*d +: 3] inside {3'd2, 3'd3, 3'd4}) any_busy = 1'b1;
    end
    ctl_pick   = (ctl_host_cmd | ctl_gc | ctl_buf_mgmt) ? e_ctl_act : e_ctl_idle;
    ctl_expect = (AW+1)'(acc_ctl) + (AW+1)'(ctl_pick);
  end

  // R1
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_ctl == '0 && acc_dram == '0 && acc_bus == '0 &&
             acc_fl_idle == '0 && acc_total == '0));

  // R2
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !clr) |=> ($stable(acc_ctl) && $stable(acc_dram) && $stable(acc_bus) &&
                            $stable(acc_fl_idle) && $stable(acc_total)));

  // R3
  p_ctl_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !clr && ctl_expect <= (AW+1)'({AW{1'b1}})) |=>
      acc_ctl == $past(ctl_expect[AW-1:0]));

  // R6
  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && bus_state != 2'd2) |=> $stable(acc_bus));

  // R7
  p_overlap_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !any_busy) |=> $stable(acc_fl_idle));

  // R9
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (acc_total >= $past(acc_total) && acc_ctl >= $past(acc_ctl)));
endmodule

bind nrg_meter nrg_meter_chk #(.ND(ND), .EW(EW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .tick_en(tick_en),
  .ctl_host_cmd(ctl_host_cmd), .ctl_gc(ctl_gc), .ctl_buf_mgmt(ctl_buf_mgmt),
  .die_state(die_state), .bus_state(bus_state),
  .e_ctl_act(e_ctl_act), .e_ctl_idle(e_ctl_idle),
  .acc_ctl(acc_ctl), .acc_dram(acc_dram), .acc_bus(acc_bus),
  .acc_fl_idle(acc_fl_idle), .acc_total(acc_total)
);

// File: tb/nrg_meter_tb_top.sv
module nrg_meter_tb_top;
  localparam int ND = 3;
  localparam int EW = 8;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXV = (64'd1 << AW) - 1;

  logic clk = 1'b0;
  logic rst, clr, tick_en, ctl_host_cmd, ctl_gc, ctl_buf_mgmt, dram_busy;
  logic [3*ND-1:0] die_state;
  logic [1:0] bus_state;
  logic [EW-1:0] e_ctl_act, e_ctl_idle, e_dram_act, e_dram_idle;
  logic [EW-1:0] e_fl_read, e_fl_write, e_fl_erase, e_fl_idle, e_bus_xfer;
  logic [AW-1:0] acc_ctl, acc_dram, acc_bus, acc_fl_idle, acc_total;
  logic [AW*ND-1:0] acc_die;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint m_ctl, m_dram, m_bus, m_ovl, m_tot;
  longint m_die [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  nrg_meter #(.ND(ND), .EW(EW), .AW(AW)) dut_i (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(longint a, longint b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  function automatic longint die_cost(int code);
    case (code)
      1: return longint'(e_fl_idle);
      2: return longint'(e_fl_read);
      3: return longint'(e_fl_write);
      4: return longint'(e_fl_erase);
      default: return 0;
    endcase
  endfunction

  task automatic model_zero();
    m_ctl = 0; m_dram = 0; m_bus = 0; m_ovl = 0; m_tot = 0;
    for (int d = 0; d < ND; d++) m_die[d] = 0;
  endtask

  task automatic compare_all();
    chk("R3 ctl", acc_ctl, m_ctl);
    chk("R4 dram", acc_dram, m_dram);
    for (int d = 0; d < ND; d++) chk("R5 die", acc_die[AW*d +: AW], m_die[d]);
    chk("R6 bus", acc_bus, m_bus);
    chk("R7 idle overlap", acc_fl_idle, m_ovl);
    chk("R8 total", acc_total, m_tot);
  endtask

  // Drive one tick at a negedge, apply it to the model, compare a cycle later (R10)
  task automatic tick();
    longint ci, di, bi, ti, n_idle;
    bit busy;
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    ci = (ctl_host_cmd | ctl_gc | ctl_buf_mgmt) ? longint'(e_ctl_act) : longint'(e_ctl_idle);
    di = dram_busy ? longint'(e_dram_act) : longint'(e_dram_idle);
    bi = (bus_state == 2'd2) ? longint'(e_bus_xfer) : 0;
    ti = ci + di + bi;
    n_idle = 0; busy = 0;
    for (int d = 0; d < ND; d++) begin
      int c;
      c = int'(die_state[3*d +: 3]);
      ti += die_cost(c);
      m_die[d] = sat(m_die[d], die_cost(c));
      if (c == 1) n_idle++;
      if (c >= 2 && c <= 4) busy = 1;
    end
    m_ctl = sat(m_ctl, ci);
    m_dram = sat(m_dram, di);
    m_bus = sat(m_bus, bi);
    m_tot = sat(m_tot, ti);
    if (busy) m_ovl = sat(m_ovl, n_idle * longint'(e_fl_idle));
    compare_all();
  endtask

  initial begin
    rst = 1'b1; clr = 1'b0; tick_en = 1'b0;
    ctl_host_cmd = 0; ctl_gc = 0; ctl_buf_mgmt = 0; dram_busy = 0;
    die_state = '0; bus_state = '0;
    e_ctl_act = 8'd7; e_ctl_idle = 8'd3; e_dram_act = 8'd11; e_dram_idle = 8'd2;
    e_fl_read = 8'd5; e_fl_write = 8'd9; e_fl_erase = 8'd13; e_fl_idle = 8'd1;
    e_bus_xfer = 8'd6;
    model_zero();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset total", acc_total, 0);
    compare_all();

    // R10: first tick visible exactly one edge later
    die_state = {3'd0, 3'd1, 3'd2};
    tick();
    chk("R10 latency ctl", acc_ctl, 3);

    // Exhaustive sweep of all die codes with varying other states
    for (int c = 0; c < 512; c++) begin
      die_state = 9'(c);
      bus_state = 2'(c % 4);
      ctl_host_cmd = 1'((c / 3) % 2);
      ctl_gc = 1'((c / 6) % 2);
      ctl_buf_mgmt = 1'((c / 12) % 2);
      dram_busy = 1'(((c >> 4) ^ c) & 1);
      tick();
    end

    // R2: no tick, states changing, nothing moves
    die_state = {3'd4, 3'd1, 3'd3}; bus_state = 2'd2; ctl_gc = 1; dram_busy = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 hold total", acc_total, m_tot);
    compare_all();

    // R1: clear wins over a tick in the same cycle
    clr = 1'b1; tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0; tick_en = 1'b0;
    model_zero();
    chk("R1 clear total", acc_total, 0);
    compare_all();

    // R9: saturation with maximal costs
    e_ctl_act = 8'hFF; e_dram_act = 8'hFF; e_fl_read = 8'hFF; e_fl_write = 8'hFF;
    e_fl_erase = 8'hFF; e_fl_idle = 8'hFF; e_bus_xfer = 8'hFF;
    ctl_host_cmd = 1; dram_busy = 1; bus_state = 2'd2;
    die_state = {3'd4, 3'd3, 3'd1};
    for (int k = 0; k < 300; k++) tick();
    chk("R9 saturated total", acc_total, MAXV);
    chk("R9 saturated ctl", acc_ctl, MAXV);
    chk("R9 saturated overlap", acc_fl_idle, MAXV);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule